// File: doc/BRIEF.md
# CAN Adapter Host Bus Glue

This block sits between a host I/O bus and an external CAN controller on an adapter card. The host sees three address windows, each with its own select line. The first is a 128-byte interrupt-control window. It holds one 32-bit control/status word, and every other offset in it reads as zero. The second is a 128-byte byte-wide window. Its lowest 32 byte addresses pass straight through to the controller's register port, and the addresses above those are dead. The third is an 8-byte identification window. It returns a fixed version byte at one offset and zero everywhere else.

The controller's interrupt line is sampled into a latched level. The host interrupt output follows that level only while a software enable bit in the control/status word is set. A write that flips the enable while a request is pending moves the host interrupt at the next clock edge. The status half of the same word reports the latched level.

Host accesses finish in the cycle they are presented: read data is combinational and writes commit at the next rising edge. No window applies back-pressure. The controller port uses the same rule and returns its read byte in the cycle of the strobe. While the device is in reset, the controller is held in hardware reset.

Top module: `can_host_glue`

## Requirements
- R1: After reset, host_irq is 0 and a read of the control/status word (interrupt window, offset 0x38) returns 0.
- R2: A full-word write at interrupt-window offset 0x38 stores the data. A read there returns the stored word with bit 23 replaced by the latched controller interrupt level. The latched level is updated at every rising edge from ctl_irq.
- R3: With bit 13 (enable) set, host_irq takes the new controller level at the edge that latches it.
- R4: When a control/status write changes bit 13 while the latched level is 1, host_irq becomes the new bit 13 value at that write's edge.
- R5: When the controller level changes while bit 13 is 0, host_irq keeps its value.
- R6: Reads at interrupt-window offsets other than 0x38 return 0, and writes there change neither the control/status word nor host_irq.
- R7: A controller-window access at addresses 0x00 to 0x1F drives ctl_rd or ctl_wr in the same cycle, with ctl_addr set to the low 5 address bits and ctl_wdata set to host_wdata[7:0]. A read returns ctl_rdata zero-extended.
- R8: A controller-window access at addresses 0x20 or above raises no controller strobe, and a read there returns 0.
- R9: An identification-window read at offset 7 returns 0xD0 (version 13 in bits 7:4, 0 in bits 3:0). Other offsets return 0, and writes have no effect.
- R10: ctl_rst is 1 exactly while rst_n is 0.
- R11: When a control/status write and a controller level change fall on the same edge, the new enable and the new level both apply, so that host_irq equals their AND after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous device reset |
| icw_sel | input | 1 | Selects the interrupt-control window |
| ccw_sel | input | 1 | Selects the controller pass-through window |
| idw_sel | input | 1 | Selects the identification window |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 7 | Byte offset within the selected window |
| host_wdata | input | 32 | Write data (byte windows use bits 7:0) |
| host_rdata | output | 32 | Read data, valid in the cycle of host_rd |
| ctl_rd | output | 1 | Controller read strobe |
| ctl_wr | output | 1 | Controller write strobe |
| ctl_addr | output | 5 | Controller register address |
| ctl_wdata | output | 8 | Controller write byte |
| ctl_rdata | input | 8 | Controller read byte, same cycle |
| ctl_irq | input | 1 | Controller interrupt level |
| ctl_rst | output | 1 | Controller hardware reset |
| host_irq | output | 1 | Gated host interrupt |

## Verification
A software write to the control/status word and a change on the controller interrupt line can land on the same clock edge. The enable logic and the level latch then both try to set host_irq. The bench provokes this by driving ctl_irq and the control/status write in the same low clock phase, in both directions: disabling as the line falls, and enabling as it rises. After the edge it expects host_irq to equal the new enable ANDed with the new level, and the status bit to show the new level.

// File: rtl/can_glue_pkg.sv
package can_glue_pkg;
  localparam int HOST_AW     = 7;
  localparam int HOST_DW     = 32;
  localparam int BYTE_W      = 8;
  localparam logic [HOST_AW-1:0] CSR_OFS = 7'h38;
  localparam int EN_BIT      = 13;
  localparam int STAT_BIT    = 23;
  localparam int FWD_LIMIT   = 32;
  localparam int ID_AW       = 3;
  localparam logic [ID_AW-1:0] ID_OFS = 3'd7;
  localparam logic [3:0] ID_VERSION = 4'd13;
endpackage

// File: rtl/can_irq_ctl.sv
module can_irq_ctl
  import can_glue_pkg::*;
#(
  parameter int AW = HOST_AW,
  parameter int DW = HOST_DW,
  parameter logic [AW-1:0] OFS = CSR_OFS,
  parameter int ENB = EN_BIT,
  parameter int STB = STAT_BIT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          ctl_irq,
  output logic [DW-1:0] rdata,
  output logic          host_irq
);
  logic [DW-1:0] csr_q;
  logic          lvl_q;
  logic          irq_q;
  logic          csr_hit, csr_wr, en_now, en_next, lvl_chg, irq_next;

  assign csr_hit = sel && (addr == OFS);
  assign csr_wr  = csr_hit && wr;
  assign en_now  = csr_q[ENB];
  assign en_next = csr_wr ? wdata[ENB] : en_now;
  assign lvl_chg = (ctl_irq != lvl_q);

  always_comb begin
    irq_next = irq_q;
    if (csr_wr && lvl_q && (en_next != en_now))
      irq_next = en_next;
    if (lvl_chg && en_next)
      irq_next = ctl_irq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr_q <= '0;
      lvl_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (csr_wr) csr_q <= wdata;
      lvl_q <= ctl_irq;
      irq_q <= irq_next;
    end
  end

  always_comb begin
    rdata = '0;
    if (csr_hit && rd) begin
      rdata      = csr_q;
      rdata[STB] = lvl_q;
    end
  end

  assign host_irq = irq_q;

  // R3 R4 R5 R11: the gated output never leaves enable AND latched level
  assert_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq == (csr_q[ENB] & lvl_q));

  // R5: a level change with the enable clear and no write leaves host_irq alone
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_chg && !en_now && !csr_wr) |=> $stable(host_irq));

  // R4: a toggle of the enable while pending drives host_irq to the new value
  assert_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && lvl_q && !lvl_chg && (wdata[ENB] != en_now)) |=> (host_irq == $past(wdata[ENB])));
endmodule

// File: rtl/can_ctl_bridge.sv
module can_ctl_bridge
  import can_glue_pkg::*;
#(
  parameter int AW    = HOST_AW,
  parameter int BW    = BYTE_W,
  parameter int LIMIT = FWD_LIMIT,
  localparam int CAW  = $clog2(LIMIT)
) (
  input  logic           rst_n,
  input  logic           sel,
  input  logic           rd,
  input  logic           wr,
  input  logic [AW-1:0]  addr,
  input  logic [BW-1:0]  wdata,
  output logic [BW-1:0]  rdata,
  output logic           ctl_rd,
  output logic           ctl_wr,
  output logic [CAW-1:0] ctl_addr,
  output logic [BW-1:0]  ctl_wdata,
  input  logic [BW-1:0]  ctl_rdata
);
  logic in_rng;

  assign in_rng    = (int'(addr) < LIMIT);
  assign ctl_rd    = sel && rd && in_rng;
  assign ctl_wr    = sel && wr && in_rng;
  assign ctl_addr  = addr[CAW-1:0];
  assign ctl_wdata = wdata;
  assign rdata     = ctl_rd ? ctl_rdata : '0;

  // R8: no strobe leaves the block for an address past the forwarded range
  always_comb begin
    if (rst_n === 1'b1 && int'(addr) >= LIMIT) begin
      assert_drop_R8: assert (!ctl_rd && !ctl_wr && rdata == '0);
    end
  end
endmodule

// File: rtl/can_id_rom.sv
module can_id_rom
  import can_glue_pkg::*;
#(
  parameter int IAW = ID_AW,
  parameter int BW  = BYTE_W,
  parameter logic [IAW-1:0] OFS = ID_OFS,
  parameter logic [3:0] VER = ID_VERSION
) (
  input  logic           rst_n,
  input  logic           sel,
  input  logic           rd,
  input  logic [IAW-1:0] addr,
  output logic [BW-1:0]  rdata
);
  localparam logic [BW-1:0] ID_BYTE = BW'({VER, 4'h0});

  assign rdata = (sel && rd && addr == OFS) ? ID_BYTE : '0;

  // R9: the identification byte at its offset carries the version in the high nibble
  always_comb begin
    if (rst_n === 1'b1 && sel && rd && addr == OFS) begin
      assert_id_R9: assert (rdata[3:0] == 4'h0 && rdata[7:4] == VER);
    end
  end
endmodule

// File: rtl/can_host_glue.sv
module can_host_glue
  import can_glue_pkg::*;
#(
  parameter int AW    = HOST_AW,
  parameter int DW    = HOST_DW,
  parameter int BW    = BYTE_W,
  parameter int LIMIT = FWD_LIMIT,
  localparam int CAW  = $clog2(LIMIT)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           icw_sel,
  input  logic           ccw_sel,
  input  logic           idw_sel,
  input  logic           host_rd,
  input  logic           host_wr,
  input  logic [AW-1:0]  host_addr,
  input  logic [DW-1:0]  host_wdata,
  output logic [DW-1:0]  host_rdata,
  output logic           ctl_rd,
  output logic           ctl_wr,
  output logic [CAW-1:0] ctl_addr,
  output logic [BW-1:0]  ctl_wdata,
  input  logic [BW-1:0]  ctl_rdata,
  input  logic           ctl_irq,
  output logic           ctl_rst,
  output logic           host_irq
);
  logic [DW-1:0] icw_rdata;
  logic [BW-1:0] ccw_rdata;
  logic [BW-1:0] idw_rdata;

  can_irq_ctl #(.AW(AW), .DW(DW)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (icw_sel),
    .rd       (host_rd),
    .wr       (host_wr),
    .addr     (host_addr),
    .wdata    (host_wdata),
    .ctl_irq  (ctl_irq),
    .rdata    (icw_rdata),
    .host_irq (host_irq)
  );

  can_ctl_bridge #(.AW(AW), .BW(BW), .LIMIT(LIMIT)) u_bridge (
    .rst_n     (rst_n),
    .sel       (ccw_sel),
    .rd        (host_rd),
    .wr        (host_wr),
    .addr      (host_addr),
    .wdata     (host_wdata[BW-1:0]),
    .rdata     (ccw_rdata),
    .ctl_rd    (ctl_rd),
    .ctl_wr    (ctl_wr),
    .ctl_addr  (ctl_addr),
    .ctl_wdata (ctl_wdata),
    .ctl_rdata (ctl_rdata)
  );

  can_id_rom #(.BW(BW)) u_id (
    .rst_n (rst_n),
    .sel   (idw_sel),
    .rd    (host_rd),
    .addr  (host_addr[ID_AW-1:0]),
    .rdata (idw_rdata)
  );

  assign host_rdata = icw_rdata | DW'(ccw_rdata) | DW'(idw_rdata);
  assign ctl_rst    = ~rst_n;

  // R10: the controller is held in reset for the whole device reset
  always_comb begin
    if (rst_n === 1'b0) begin
      assert_ctl_reset_R10: assert (ctl_rst);
    end
  end

  // R1: the host interrupt comes out of reset deasserted
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !host_irq);
endmodule

// File: tb/can_host_glue_test.sv
module can_host_glue_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        icw_sel = 1'b0, ccw_sel = 1'b0, idw_sel = 1'b0;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [6:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        ctl_rd, ctl_wr, ctl_rst, host_irq;
  logic [4:0]  ctl_addr;
  logic [7:0]  ctl_wdata, ctl_rdata;
  logic        ctl_irq = 1'b0;
  int          n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  assign ctl_rdata = {3'b101, ctl_addr};

  can_host_glue uut (
    .clk(clk), .rst_n(rst_n), .icw_sel(icw_sel), .ccw_sel(ccw_sel), .idw_sel(idw_sel),
    .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .ctl_rd(ctl_rd), .ctl_wr(ctl_wr), .ctl_addr(ctl_addr),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .ctl_irq(ctl_irq), .ctl_rst(ctl_rst),
    .host_irq(host_irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive_sel(input int win);
    icw_sel = (win == 0);
    ccw_sel = (win == 1);
    idw_sel = (win == 2);
  endtask

  task automatic idle();
    icw_sel = 0; ccw_sel = 0; idw_sel = 0; host_rd = 0; host_wr = 0;
  endtask

  // write commits at the posedge inside this task; returns at the next negedge
  task automatic wr_acc(input int win, input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    drive_sel(win); host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk);
    idle();
  endtask

  task automatic rd_acc(input int win, input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    drive_sel(win); host_addr = a; host_rd = 1;
    #1 d = host_rdata;
    idle();
  endtask

  task automatic set_irq(input logic v);
    @(negedge clk);
    ctl_irq = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    @(negedge clk);
    check("R10 ctl_rst in reset", 32'(ctl_rst), 1);
    check("R1 host_irq in reset", 32'(host_irq), 0);
    rst_n = 1;
    @(negedge clk);
    check("R10 ctl_rst after reset", 32'(ctl_rst), 0);
    rd_acc(0, 7'h38, d);
    check("R1 csr after reset", d, 0);
  endtask

  task automatic t_csr_rw();
    logic [31:0] d;
    wr_acc(0, 7'h38, 32'h12B4_5678);
    rd_acc(0, 7'h38, d);
    check("R2 csr readback hides stored bit 23", d, 32'h1234_5678);
    wr_acc(0, 7'h38, 32'h0);
  endtask

  task automatic t_gate();
    logic [31:0] d;
    set_irq(1);
    check("R5 level rise while disabled", 32'(host_irq), 0);
    rd_acc(0, 7'h38, d);
    check("R2 status bit shows level", d, 32'h0080_0000);
    wr_acc(0, 7'h38, 32'h2000);
    check("R4 enable while pending", 32'(host_irq), 1);
    wr_acc(0, 7'h38, 32'h0);
    check("R4 disable while pending", 32'(host_irq), 0);
    set_irq(0);
    check("R5 level fall while disabled", 32'(host_irq), 0);
    wr_acc(0, 7'h38, 32'h2000);
    check("R3 enable with no request", 32'(host_irq), 0);
    set_irq(1);
    check("R3 follows rise when enabled", 32'(host_irq), 1);
    set_irq(0);
    check("R3 follows fall when enabled", 32'(host_irq), 0);
    set_irq(1);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    // enabled, level 1: disable and drop the line on the same edge
    @(negedge clk);
    drive_sel(0); host_addr = 7'h38; host_wdata = 32'h0; host_wr = 1; ctl_irq = 0;
    @(negedge clk);
    idle();
    check("R11 disable plus fall", 32'(host_irq), 0);
    rd_acc(0, 7'h38, d);
    check("R11 status after disable plus fall", d, 0);
    // enable and raise the line on the same edge
    @(negedge clk);
    drive_sel(0); host_addr = 7'h38; host_wdata = 32'h2000; host_wr = 1; ctl_irq = 1;
    @(negedge clk);
    idle();
    check("R11 enable plus rise", 32'(host_irq), 1);
    rd_acc(0, 7'h38, d);
    check("R11 status after enable plus rise", d, 32'h0080_2000);
  endtask

  task automatic t_other();
    logic [31:0] d;
    wr_acc(0, 7'h3C, 32'hFFFF_FFFF);
    wr_acc(0, 7'h0C, 32'h0);
    check("R6 host_irq untouched by other offsets", 32'(host_irq), 1);
    rd_acc(0, 7'h3C, d);
    check("R6 other offset reads zero", d, 0);
    rd_acc(0, 7'h38, d);
    check("R6 csr unchanged", d, 32'h0080_2000);
  endtask

  task automatic t_fwd();
    logic [31:0] d;
    @(negedge clk);
    drive_sel(1); host_addr = 7'h05; host_wdata = 32'hAAAA_AA3C; host_wr = 1;
    #1;
    check("R7 write strobe", 32'(ctl_wr), 1);
    check("R7 write address", 32'(ctl_addr), 5);
    check("R7 write byte", 32'(ctl_wdata), 32'h3C);
    idle();
    rd_acc(1, 7'h1F, d);
    check("R7 read top forwarded byte", d, 32'hBF);
  endtask

  task automatic t_drop();
    logic [31:0] d;
    @(negedge clk);
    drive_sel(1); host_addr = 7'h20; host_wdata = 32'h55; host_wr = 1;
    #1;
    check("R8 no write strobe at 0x20", 32'(ctl_wr), 0);
    idle();
    @(negedge clk);
    drive_sel(1); host_addr = 7'h7F; host_rd = 1;
    #1;
    check("R8 no read strobe at 0x7F", 32'(ctl_rd), 0);
    check("R8 read 0x7F is zero", host_rdata, 0);
    idle();
  endtask

  task automatic t_id();
    logic [31:0] d;
    rd_acc(2, 7'h07, d);
    check("R9 id byte", d, 32'hD0);
    rd_acc(2, 7'h03, d);
    check("R9 other id offset", d, 0);
    wr_acc(2, 7'h07, 32'hFF);
    rd_acc(2, 7'h07, d);
    check("R9 id byte after write", d, 32'hD0);
  endtask

  initial begin
    t_reset();
    t_csr_rw();
    t_gate();
    t_collide();
    t_other();
    t_fwd();
    t_drop();
    t_id();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule